// File: doc/BRIEF.md
# Asynchronous NAND Bus Timing Sequencer

This block drives the pins of an asynchronous NAND flash device: chip enable, the command and address latch strobes, the write and read strobes, and an 8-bit data bus with an output enable. A client hands it one bus cycle at a time over a valid/ready request port. Each request carries a cycle type, a byte and a flag that marks the last cycle of a burst. The block places every strobe edge on whole clock cycles, using three programmable counts: an address setup count, a data setup count and a data hold count.

Chip enable falls once at the start of a burst and rises only after the cycle flagged last. Before each read strobe the block waits for the device's ready/busy line to report ready, then waits a further fixed interval. The byte on the bus at the read strobe's rising edge is returned on a one-cycle valid pulse. The three counts are captured when a burst begins, so software may rewrite them at any time without disturbing a burst that is in progress.

Top module: `nand_bus_seq`

## Requirements
- R1: Out of reset, chip enable and both strobes are high (inactive), both latch enables are low, the data output enable is low, the read valid pulse is low and the request port is ready.
- R2: In a write-type cycle (type 0 command, type 1 address, type 2 data write) the write strobe is low for exactly DS cycles and then high for at least DH cycles before any following strobe falls.
- R3: In a command cycle only the command latch enable is asserted, and in an address cycle only the address latch enable is asserted. The enable rises AS+DS cycles before the write strobe rises and falls DH cycles after it. A data write (type 2) asserts neither enable.
- R4: Chip enable falls AS+DS+1 cycles before the first write strobe rising edge of a burst. It stays low across the burst and rises DH+1 cycles after the rising edge of the last cycle's strobe.
- R5: The request byte is on the data bus with the output enable high from before the write strobe falls until the end of the hold interval. The output enable is low whenever the read strobe is low.
- R6: In a read cycle (type 3) the read strobe is low for exactly DS cycles. The bus value sampled at its rising edge appears on the read byte output, with read valid high for exactly one cycle: the first cycle in which the read strobe is high.
- R7: The read strobe does not fall while the block is waiting for ready. It falls no sooner than AS+2 cycles after the ready/busy input is seen high.
- R8: The request port is ready only when the block is idle or between cycles of a burst. It is never ready while a strobe is low. A cycle flagged last ends the burst.
- R9: AS, DS and DH are captured when a burst starts. Changing the count inputs during a burst does not alter that burst's timing.
- R10: An AS of 0 is honoured. A DS or DH of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle when valid is high |
| req_kind | input | 2 | Cycle type: 0 command, 1 address, 2 data write, 3 data read |
| req_byte | input | 8 | Byte to write (ignored for reads) |
| req_last | input | 1 | Last cycle of the burst |
| cfg_as | input | CW | Address setup count |
| cfg_ds | input | CW | Data setup count |
| cfg_dh | input | CW | Data hold count |
| nand_rdy | input | 1 | Device ready/busy, high when ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus in |
| rd_valid | output | 1 | One-cycle pulse with a captured byte |
| rd_byte | output | 8 | Captured read byte |

## Verification
The bench goes after off-by-one errors at every edge. It measures the distance between chip enable, the latch enables and the strobes in whole cycles. A sequencer that merged the chip-enable setup cycle into the address setup, or dropped the extra release cycle, would show AS+DS or DH instead of the +1 distances. A setup of AS=0 exposes a design that still spends one address-setup cycle, and DS=DH=0 exposes one that underflows its counter into a long pulse. During one burst the ready line is held low and the count inputs are rewritten. This catches a read strobe that falls during the busy phase or too soon after ready, and a design that takes up new counts in mid-burst.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_WR   = 2'd2,
    K_RD   = 2'd3
  } kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CES, S_ASU, S_DSU, S_HLD, S_GAP, S_CEH,
    S_RBSY, S_RPRE, S_RLO, S_RHI
  } st_t;
endpackage

// File: rtl/nbs_cfg_latch.sv
module nbs_cfg_latch #(
  parameter int CW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [2:0][CW-1:0]  cnt_i,
  output logic [2:0][CW-1:0]  cnt_o
);
  // field 0: address setup (0 allowed); fields 1,2: data setup/hold (min 1)
  for (genvar i = 0; i < 3; i++) begin : g_field
    localparam logic [CW-1:0] MINV = (i == 0) ? '0 : CW'(1);
    logic [CW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)       q <= MINV;
      else if (load) q <= (cnt_i[i] < MINV) ? MINV : cnt_i[i];
    end
    assign cnt_o[i] = q;
  end
endmodule

// File: rtl/nbs_fsm.sv
module nbs_fsm import nbs_pkg::*; #(
  parameter int CW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_byte,
  input  logic          req_last,
  input  logic          rdy,
  input  logic [CW-1:0] as_c,
  input  logic [CW-1:0] ds_c,
  input  logic [CW-1:0] dh_c,
  output logic          burst_start,
  output st_t           st_q,
  output st_t           st_d,
  output kind_t         kind_d,
  output logic [DW-1:0] byte_d
);
  localparam int NW = CW + 1;

  logic [NW-1:0] cnt_q, cnt_d;
  kind_t         kind_q;
  logic [DW-1:0] byte_q;
  logic          last_q, last_d;
  logic          accept, go_w, go_r, fin;
  logic [NW-1:0] as_w, ds_w, dh_w;

  assign as_w = NW'(as_c);
  assign ds_w = NW'(ds_c);
  assign dh_w = NW'(dh_c);

  always_comb begin
    st_d      = st_q;
    cnt_d     = (cnt_q != '0) ? cnt_q - NW'(1) : '0;
    kind_d    = kind_q;
    byte_d    = byte_q;
    last_d    = last_q;
    req_ready = (st_q == S_IDLE) || (st_q == S_GAP);
    accept    = req_ready && req_valid;
    go_w      = 1'b0;
    go_r      = 1'b0;
    fin       = 1'b0;
    if (accept) begin
      kind_d = kind_t'(req_kind);
      byte_d = req_byte;
      last_d = req_last;
    end
    case (st_q)
      S_IDLE: if (accept) st_d = S_CES;
      S_CES:  if (kind_q == K_RD) go_r = 1'b1; else go_w = 1'b1;
      S_GAP:  if (accept) begin
                if (kind_t'(req_kind) == K_RD) go_r = 1'b1; else go_w = 1'b1;
              end
      S_ASU:  if (cnt_q == '0) begin st_d = S_DSU; cnt_d = ds_w - NW'(1); end
      S_DSU:  if (cnt_q == '0) begin st_d = S_HLD; cnt_d = dh_w - NW'(1); end
      S_HLD:  if (cnt_q == '0) fin = 1'b1;
      S_RBSY: if (rdy) begin st_d = S_RPRE; cnt_d = as_w + NW'(1); end
      S_RPRE: if (cnt_q == '0) begin st_d = S_RLO; cnt_d = ds_w - NW'(1); end
      S_RLO:  if (cnt_q == '0) begin st_d = S_RHI; cnt_d = dh_w - NW'(1); end
      S_RHI:  if (cnt_q == '0) fin = 1'b1;
      S_CEH:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (go_r) st_d = S_RBSY;
    if (go_w) begin
      if (as_w == '0) begin st_d = S_DSU; cnt_d = ds_w - NW'(1); end
      else            begin st_d = S_ASU; cnt_d = as_w - NW'(1); end
    end
    if (fin) st_d = last_q ? S_CEH : S_GAP;
  end

  assign burst_start = accept && (st_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      kind_q <= K_CMD;
      byte_q <= '0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      byte_q <= byte_d;
      last_q <= last_d;
    end
  end

  // R7: no progress toward the read strobe while the device reports busy
  a_r7_busy_wait: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_RBSY && !rdy) |=> (st_q == S_RBSY));

  // R8: a request taken while idle opens a burst with the chip-enable setup cycle
  a_r8_burst_open: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && st_q == S_IDLE) |=> (st_q == S_CES));
endmodule

// File: rtl/nbs_pins.sv
module nbs_pins import nbs_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  st_t           st_q,
  input  st_t           st_d,
  input  kind_t         kind_d,
  input  logic [DW-1:0] byte_d,
  input  logic [DW-1:0] dq_in,
  input  logic          req_ready,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          rd_valid,
  output logic [DW-1:0] rd_byte
);
  logic in_w, cap;

  always_comb begin
    in_w = (st_d == S_ASU) || (st_d == S_DSU) || (st_d == S_HLD);
    cap  = (st_q == S_RLO) && (st_d == S_RHI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n     <= 1'b1;
      cle      <= 1'b0;
      ale      <= 1'b0;
      we_n     <= 1'b1;
      re_n     <= 1'b1;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else begin
      ce_n     <= (st_d == S_IDLE);
      cle      <= in_w && (kind_d == K_CMD);
      ale      <= in_w && (kind_d == K_ADDR);
      we_n     <= (st_d != S_DSU);
      re_n     <= (st_d != S_RLO);
      dq_out   <= byte_d;
      dq_oe    <= in_w;
      rd_valid <= cap;
      if (cap) rd_byte <= dq_in;
    end
  end

  // R2: the two strobes never overlap
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
  // R3: at most one latch enable at a time
  a_r3_latch_excl: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));
  // R4: any bus activity happens under chip enable
  a_r4_ce_covers: assert property (@(posedge clk) disable iff (rst)
    (!we_n || !re_n || cle || ale || dq_oe) |-> !ce_n);
  // R5: bus driven whenever the write strobe is low, released under the read strobe
  a_r5_bus_drive: assert property (@(posedge clk) disable iff (rst)
    (!we_n |-> dq_oe) and (!re_n |-> !dq_oe));
  // R6: read valid is a single-cycle pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  // R8: the request port stays closed while a strobe is low
  a_r8_ready_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (we_n && re_n));
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq import nbs_pkg::*; #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [7:0]    req_byte,
  input  logic          req_last,
  input  logic [CW-1:0] cfg_as,
  input  logic [CW-1:0] cfg_ds,
  input  logic [CW-1:0] cfg_dh,
  input  logic          nand_rdy,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [7:0]    nand_dq_out,
  output logic          nand_dq_oe,
  input  logic [7:0]    nand_dq_in,
  output logic          rd_valid,
  output logic [7:0]    rd_byte
);
  localparam int DW = 8;

  logic [2:0][CW-1:0] cnt_in, cnt_lat;
  logic               burst_start;
  st_t                st_q, st_d;
  kind_t              kind_d;
  logic [DW-1:0]      byte_d;

  assign cnt_in = {cfg_dh, cfg_ds, cfg_as};

  nbs_cfg_latch #(.CW(CW)) u_cfg (
    .clk(clk), .rst(rst), .load(burst_start), .cnt_i(cnt_in), .cnt_o(cnt_lat)
  );

  nbs_fsm #(.CW(CW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_byte(req_byte), .req_last(req_last), .rdy(nand_rdy),
    .as_c(cnt_lat[0]), .ds_c(cnt_lat[1]), .dh_c(cnt_lat[2]),
    .burst_start(burst_start), .st_q(st_q), .st_d(st_d),
    .kind_d(kind_d), .byte_d(byte_d)
  );

  nbs_pins #(.DW(DW)) u_pins (
    .clk(clk), .rst(rst), .st_q(st_q), .st_d(st_d), .kind_d(kind_d),
    .byte_d(byte_d), .dq_in(nand_dq_in), .req_ready(req_ready),
    .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
    .rd_valid(rd_valid), .rd_byte(rd_byte)
  );
endmodule

// File: tb/nand_bus_seq_tb.sv
module nand_bus_seq_tb;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic [7:0]    req_byte = 8'h00;
  logic          req_last = 1'b0;
  logic [CW-1:0] cfg_as = 4'd1, cfg_ds = 4'd1, cfg_dh = 4'd1;
  logic          nand_rdy = 1'b1;
  logic          ce_n, cle, ale, we_n, re_n, dq_oe, rd_valid;
  logic [7:0]    dq_out, rd_byte;
  logic [7:0]    dq_in = 8'h00;

  always #2.5 clk = ~clk;

  nand_bus_seq #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_byte(req_byte), .req_last(req_last),
    .cfg_as(cfg_as), .cfg_ds(cfg_ds), .cfg_dh(cfg_dh), .nand_rdy(nand_rdy),
    .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n),
    .nand_re_n(re_n), .nand_dq_out(dq_out), .nand_dq_oe(dq_oe),
    .nand_dq_in(dq_in), .rd_valid(rd_valid), .rd_byte(rd_byte)
  );

  int checks = 0, failures = 0;
  int exp_as = 1, exp_ds = 1, exp_dh = 1;
  logic [9:0] wq[$];
  logic [7:0] mq[$];
  logic [7:0] rq[$];
  int n_rd = 0, last_wlow = 0, last_rlow = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  int  cyc = 0;
  int  t_ce_f = 0, t_lat = 0, t_wf = 0, t_rf = 0, t_rise = 0, t_rdy = 0;
  bit  first = 1'b0;
  logic p_ce = 1'b1, p_lat = 1'b0, p_we = 1'b1, p_re = 1'b1, p_rdy = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (p_rdy == 1'b0 && nand_rdy == 1'b1) t_rdy = cyc;
      if (p_ce && !ce_n) begin t_ce_f = cyc; first = 1'b1; end
      if (!p_lat && (cle || ale)) t_lat = cyc;
      if (p_we && !we_n) begin
        t_wf = cyc;
        chk(wq.size() > 0, "R5 write item queued", wq.size(), 1);
        if (wq.size() > 0)
          chk(dq_oe && dq_out == wq[0][7:0], "R5 data at strobe fall", dq_out, wq[0][7:0]);
        chk(!req_ready, "R8 ready low during strobe", req_ready, 0);
      end
      if (!p_we && we_n) begin
        logic [9:0] it;
        last_wlow = cyc - t_wf;
        chk(cyc - t_wf == exp_ds, "R2 write strobe low width", cyc - t_wf, exp_ds);
        it = (wq.size() > 0) ? wq.pop_front() : 10'h3FF;
        chk(cle == (it[9:8] == 2'd0), "R3 command latch at edge", cle, it[9:8] == 2'd0);
        chk(ale == (it[9:8] == 2'd1), "R3 address latch at edge", ale, it[9:8] == 2'd1);
        if (it[9:8] != 2'd2)
          chk(cyc - t_lat == exp_as + exp_ds, "R3 latch setup", cyc - t_lat, exp_as + exp_ds);
        if (first)
          chk(cyc - t_ce_f == exp_as + exp_ds + 1, "R4 chip enable setup",
              cyc - t_ce_f, exp_as + exp_ds + 1);
        chk(dq_oe && dq_out == it[7:0], "R5 data held past edge", dq_out, it[7:0]);
        first = 1'b0;
        t_rise = cyc;
      end
      if (p_lat && !(cle || ale))
        chk(cyc - t_rise == exp_dh, "R3 latch hold", cyc - t_rise, exp_dh);
      if (p_re && !re_n) begin
        t_rf = cyc;
        chk(nand_rdy && (cyc - t_rdy >= exp_as + 2), "R7 read strobe after ready",
            cyc - t_rdy, exp_as + 2);
        if (!first)
          chk(cyc - t_rise >= exp_dh, "R2 high time before next strobe", cyc - t_rise, exp_dh);
        if (mq.size() > 0) begin
          dq_in = mq.pop_front();
          rq.push_back(dq_in);
        end
      end
      if (!p_re && re_n) begin
        last_rlow = cyc - t_rf;
        chk(cyc - t_rf == exp_ds, "R6 read strobe low width", cyc - t_rf, exp_ds);
        first = 1'b0;
        t_rise = cyc;
      end
      if (rd_valid) begin
        logic [7:0] e;
        n_rd++;
        e = (rq.size() > 0) ? rq.pop_front() : 8'hXX;
        chk(rd_byte == e, "R6 captured byte", rd_byte, e);
        chk(cyc == t_rise, "R6 valid in first high cycle", cyc, t_rise);
      end
      if (!p_ce && ce_n)
        chk(cyc - t_rise == exp_dh + 1, "R4 chip enable release", cyc - t_rise, exp_dh + 1);
      p_ce = ce_n; p_lat = cle || ale; p_we = we_n; p_re = re_n; p_rdy = nand_rdy;
    end
  end

  // driver
  task automatic start_burst(input int a, input int d, input int h);
    @(negedge clk);
    while (!(ce_n && req_ready)) @(negedge clk);
    @(negedge clk);
    cfg_as = CW'(a); cfg_ds = CW'(d); cfg_dh = CW'(h);
    exp_as = a; exp_ds = (d == 0) ? 1 : d; exp_dh = (h == 0) ? 1 : h;
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] b, input bit last);
    if (k != 2'd3) wq.push_back({k, b}); else mq.push_back(b);
    req_kind = k; req_byte = b; req_last = last; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ce_n && we_n && re_n, "R1 strobes inactive", {ce_n, we_n, re_n}, 3'b111);
    chk(!cle && !ale && !dq_oe && !rd_valid, "R1 enables low",
        {cle, ale, dq_oe, rd_valid}, 0);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // burst A: program-style write sequence
    start_burst(1, 2, 1);
    send(2'd0, 8'h80, 1'b0);
    send(2'd1, 8'h12, 1'b0);
    send(2'd1, 8'h34, 1'b0);
    send(2'd2, 8'hA5, 1'b0);
    send(2'd2, 8'h5A, 1'b1);

    // burst B: R10 address setup of zero, status read
    start_burst(0, 1, 1);
    send(2'd0, 8'h70, 1'b0);
    send(2'd3, 8'hC3, 1'b1);

    // burst C: R7 busy wait and R9 counts changed mid-burst
    start_burst(2, 3, 2);
    send(2'd0, 8'h00, 1'b0);
    cfg_as = 4'd7; cfg_ds = 4'd7; cfg_dh = 4'd7;
    send(2'd1, 8'h21, 1'b0);
    send(2'd0, 8'h30, 1'b0);
    @(posedge clk); nand_rdy <= 1'b0;
    fork
      begin repeat (20) @(posedge clk); nand_rdy <= 1'b1; end
    join_none
    @(negedge clk);
    send(2'd3, 8'h3C, 1'b0);
    send(2'd3, 8'h96, 1'b0);
    send(2'd3, 8'h0F, 1'b1);
    start_burst(2, 3, 2);
    chk(last_rlow == 3, "R9 latched data setup used", last_rlow, 3);

    // burst D: R10 zero data setup and hold act as one
    start_burst(3, 0, 0);
    send(2'd2, 8'hE7, 1'b0);
    send(2'd3, 8'h55, 1'b1);
    start_burst(1, 1, 1);
    chk(last_wlow == 1, "R10 zero setup clamped", last_wlow, 1);
    chk(last_rlow == 1, "R10 zero setup clamped on read", last_rlow, 1);

    chk(n_rd == 5, "R6 read count", n_rd, 5);
    chk(wq.size() == 0 && mq.size() == 0 && rq.size() == 0, "R8 all cycles completed",
        wq.size() + mq.size() + rq.size(), 0);
    chk(ce_n && req_ready, "R8 idle after last", {ce_n, req_ready}, 3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule